// File: doc/BRIEF.md
# Gated Up/Down Timer Control

This block holds one core counter and a set of auxiliary counters (two by default), each 16 bits wide by default. Software starts and stops the core counter with a run input. When gating is on, the core counter also needs an external gate pin at a programmable active level. Each auxiliary counter follows either its own run input or, when its remote-run bit is set, the core counter's run input.

Every counter has its own direction controls. A software direction bit alone selects the direction, or, when external direction is enabled, the XOR of an external pin and that bit selects it. A registered status bit per counter shows the direction in effect. The gate and direction pins go through a synchroniser before use.

A counter moves by one on each clock where its count-enable tick is high and its run condition holds. It wraps around in both directions. A software load of a new value wins over counting in the same clock.

Top module: `gpt_timer_block`

## Requirements
- R1: While the synchronous reset `rst` is high, every counter is held at 0 and every `dir_stat` bit at 0 (up). This holds whatever the run, tick and direction inputs are doing.
- R2: With `core_run` low, the core counter (index 0) holds its value even when its tick is high. Raising `core_run` lets it count, and lowering it stops it again.
- R3: With `gate_en` high, the core counter advances only when the synchronised `gate_pin` equals `gate_act_hi`: 1 means active-high, 0 means active-low. The gate level seen at the third rising edge after a pin change is the new level. With `gate_en` low, the gate pin has no effect.
- R4: For auxiliary counter i (index i+1), when `aux_remote[i]` is 1, `core_run` sets its run condition and `aux_run[i]` is ignored. When `aux_remote[i]` is 0, `aux_run[i]` sets its run condition.
- R5: When `dir_ext_en[t]` is 0, `dir_sw[t]` alone selects the direction of counter t: 0 counts up and 1 counts down.
- R6: When `dir_ext_en[t]` is 1, counter t counts down when the synchronised `dir_pin[t]` XOR `dir_sw[t]` is 1, and up when it is 0.
- R7: `dir_stat[t]` (0 = up, 1 = down) shows the direction applied at the most recent rising edge. A change of `dir_sw` or `dir_ext_en` takes effect on the next edge, whether or not the counter runs. A change of `dir_pin` takes effect on the third edge.
- R8: A running counter with its tick high moves by exactly one per clock and wraps modulo 2^16: 0xFFFF+1 gives 0x0000 and 0x0000-1 gives 0xFFFF.
- R9: When `load_en[t]` is high, counter t takes `load_val` slice t at the next edge, even if it would have counted in that clock.
- R10: With its tick low and no load, a counter holds its value even when its run condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_run | input | 1 | Core counter run bit; also run source for remote-controlled auxiliaries |
| gate_en | input | 1 | Enables gated operation of the core counter |
| gate_act_hi | input | 1 | Gate active level: 1 high, 0 low |
| gate_pin | input | 1 | Asynchronous gate pin |
| aux_run | input | N_AUX | Own run bits of the auxiliary counters |
| aux_remote | input | N_AUX | Per auxiliary: take run control from core_run |
| tick | input | N_AUX+1 | Count-enable tick per counter (index 0 = core) |
| dir_sw | input | N_AUX+1 | Software direction bit per counter |
| dir_ext_en | input | N_AUX+1 | Selects pin-based direction per counter |
| dir_pin | input | N_AUX+1 | Asynchronous direction pin per counter |
| load_en | input | N_AUX+1 | Load strobe per counter |
| load_val | input | (N_AUX+1)*CNT_W | Load values, counter t in slice t |
| count | output | (N_AUX+1)*CNT_W | Counter values, counter t in slice t |
| dir_stat | output | N_AUX+1 | Direction status per counter, 0 up, 1 down |

## Verification
Loads, software direction changes and run or tick changes show in `count` and `dir_stat` right after the next rising edge. A change on `gate_pin` or `dir_pin` shows only after the third edge, because of the two synchroniser flops. The bench drives inputs on the falling edge and reads results on later falling edges, counting edges from the drive. In the sweeps it lets three quiet edges pass after setting a pin before it opens the tick window. In the timing tests it checks the value after the second edge (old behaviour) and after the third edge (new behaviour).

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  // Effective direction from software bit, pin enable and synchronised pin
  function automatic dir_e eff_dir(input logic sw, input logic ext_en, input logic pin_s);
    logic down;
    down = ext_en ? (pin_s ^ sw) : sw;
    return down ? DIR_DOWN : DIR_UP;
  endfunction

endpackage

// File: rtl/gpt_sync.sv
module gpt_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= d_async;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpt_dir_ctrl.sv
module gpt_dir_ctrl
  import gpt_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sw,
  input  logic ext_en,
  input  logic pin,
  output logic down,
  output logic down_stat
);

  logic pin_s;
  dir_e dir_now;

  gpt_sync #(.WIDTH(1), .STAGES(STAGES)) i_pin_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(pin),
    .q_sync (pin_s)
  );

  always_comb begin
    dir_now = eff_dir(sw, ext_en, pin_s);
    down    = (dir_now == DIR_DOWN);
  end

  always_ff @(posedge clk) begin
    if (rst) down_stat <= 1'b0;
    else     down_stat <= down;
  end

  // R5: software-only direction shows in status one edge later
  p_dir_sw_r5: assert property (@(posedge clk) disable iff (rst)
    !ext_en |=> down_stat == $past(sw));

endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             run,
  input  logic             tick,
  input  logic             down,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  assign step = run & tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ld_en) begin
      cnt_q <= ld_val;
    end else if (step) begin
      cnt_q <= down ? (cnt_q - ONE) : (cnt_q + ONE);
    end
  end

  p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> cnt_q == $past(ld_val));

  p_step_up_r8: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && run && tick && !down) |=> cnt_q == CNT_W'($past(cnt_q) + ONE));

  p_step_down_r8: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && run && tick && down) |=> cnt_q == CNT_W'($past(cnt_q) - ONE));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/gpt_timer_block.sv
module gpt_timer_block #(
  parameter int CNT_W  = 16,
  parameter int N_AUX  = 2,
  parameter int STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         core_run,
  input  logic                         gate_en,
  input  logic                         gate_act_hi,
  input  logic                         gate_pin,
  input  logic [N_AUX-1:0]             aux_run,
  input  logic [N_AUX-1:0]             aux_remote,
  input  logic [N_AUX:0]               tick,
  input  logic [N_AUX:0]               dir_sw,
  input  logic [N_AUX:0]               dir_ext_en,
  input  logic [N_AUX:0]               dir_pin,
  input  logic [N_AUX:0]               load_en,
  input  logic [(N_AUX+1)*CNT_W-1:0]   load_val,
  output logic [(N_AUX+1)*CNT_W-1:0]   count,
  output logic [N_AUX:0]               dir_stat
);

  localparam int N_TMR = N_AUX + 1;

  logic             gate_s;
  logic             gate_ok;
  logic [N_TMR-1:0] run_vec;
  logic [N_TMR-1:0] down_vec;

  gpt_sync #(.WIDTH(1), .STAGES(STAGES)) i_gate_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(gate_pin),
    .q_sync (gate_s)
  );

  assign gate_ok    = ~gate_en | (gate_s == gate_act_hi);
  assign run_vec[0] = core_run & gate_ok;

  generate
    for (genvar a = 0; a < N_AUX; a++) begin : g_aux_run
      assign run_vec[a+1] = aux_remote[a] ? core_run : aux_run[a];

      // R4: a remote-controlled auxiliary stays still while core_run is low
      p_remote_stop_r4: assert property (@(posedge clk) disable iff (rst)
        (aux_remote[a] && !core_run && !load_en[a+1])
          |=> $stable(count[(a+1)*CNT_W +: CNT_W]));
    end

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
      gpt_dir_ctrl #(.STAGES(STAGES)) i_dir (
        .clk      (clk),
        .rst      (rst),
        .sw       (dir_sw[t]),
        .ext_en   (dir_ext_en[t]),
        .pin      (dir_pin[t]),
        .down     (down_vec[t]),
        .down_stat(dir_stat[t])
      );

      gpt_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst   (rst),
        .ld_en (load_en[t]),
        .ld_val(load_val[t*CNT_W +: CNT_W]),
        .run   (run_vec[t]),
        .tick  (tick[t]),
        .down  (down_vec[t]),
        .cnt_q (count[t*CNT_W +: CNT_W])
      );
    end
  endgenerate

  // R3: an inactive synchronised gate freezes the core counter
  p_gate_block_r3: assert property (@(posedge clk) disable iff (rst)
    (gate_en && (gate_s != gate_act_hi) && !load_en[0])
      |=> $stable(count[CNT_W-1:0]));

  // R2: core run low freezes the core counter
  p_core_stop_r2: assert property (@(posedge clk) disable iff (rst)
    (!core_run && !load_en[0]) |=> $stable(count[CNT_W-1:0]));

endmodule

// File: tb/test_gpt_timer_block.sv
module test_gpt_timer_block;

  localparam int W  = 16;
  localparam int NA = 2;
  localparam int NT = NA + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic core_run = 0, gate_en = 0, gate_act_hi = 0, gate_pin = 0;
  logic [NA-1:0] aux_run = '0, aux_remote = '0;
  logic [NT-1:0] tick = '0, dir_sw = '0, dir_ext_en = '0, dir_pin = '0, load_en = '0;
  logic [NT*W-1:0] load_val = '0;
  logic [NT*W-1:0] count;
  logic [NT-1:0]   dir_stat;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  gpt_timer_block #(.CNT_W(W), .N_AUX(NA), .STAGES(2)) i_gpt_timer_block (
    .clk(clk), .rst(rst), .core_run(core_run), .gate_en(gate_en),
    .gate_act_hi(gate_act_hi), .gate_pin(gate_pin), .aux_run(aux_run),
    .aux_remote(aux_remote), .tick(tick), .dir_sw(dir_sw),
    .dir_ext_en(dir_ext_en), .dir_pin(dir_pin), .load_en(load_en),
    .load_val(load_val), .count(count), .dir_stat(dir_stat)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] cnt_of(input int t);
    return count[t*W +: W];
  endfunction

  task automatic load(input int t, input logic [W-1:0] v);
    load_en[t] = 1'b1;
    load_val[t*W +: W] = v;
    step(1);
    load_en[t] = 1'b0;
  endtask

  task automatic run_ticks(input int t, input int n);
    tick[t] = 1'b1;
    step(n);
    tick[t] = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset holds everything at zero despite active controls
    step(1);
    core_run = 1; aux_run = '1; tick = '1; dir_sw = '1;
    step(3);
    for (int t = 0; t < NT; t++) chk("R1 count in reset", cnt_of(t), 0);
    chk("R1 dir_stat in reset", dir_stat, 0);
    tick = '0; dir_sw = '0;
    rst = 1'b0;
    step(1);
    for (int t = 0; t < NT; t++) chk("R1 count after reset", cnt_of(t), 0);

    // R5 R6 R7: direction truth table for every counter
    for (int t = 0; t < NT; t++) begin
      for (int c = 0; c < 8; c++) begin
        logic exp_dn;
        load(t, 16'd1000);
        dir_ext_en[t] = c[2]; dir_sw[t] = c[1]; dir_pin[t] = c[0];
        step(3);
        exp_dn = c[2] ? (c[0] ^ c[1]) : c[1];
        chk("R7 dir_stat truth table", dir_stat[t], exp_dn);
        run_ticks(t, 5);
        chk(c[2] ? "R6 pin xor sw count" : "R5 software dir count",
            cnt_of(t), exp_dn ? 995 : 1005);
      end
      dir_ext_en[t] = 0; dir_sw[t] = 0; dir_pin[t] = 0;
    end

    // R7: pin direction change lands on the third edge
    dir_ext_en[1] = 1; dir_sw[1] = 0; dir_pin[1] = 0;
    load(1, 16'd500);
    step(3);
    dir_pin[1] = 1; tick[1] = 1;
    step(2);
    chk("R7 pin dir not yet applied cnt", cnt_of(1), 502);
    chk("R7 pin dir not yet applied stat", dir_stat[1], 0);
    step(1);
    chk("R7 pin dir applied cnt", cnt_of(1), 501);
    chk("R7 pin dir applied stat", dir_stat[1], 1);
    tick[1] = 0;
    dir_ext_en[1] = 0; dir_pin[1] = 0;
    // R7: software direction change lands on the next edge, even when stopped
    load(1, 16'd500);
    dir_sw[1] = 1; tick[1] = 1;
    step(1);
    tick[1] = 0;
    chk("R7 sw dir next edge cnt", cnt_of(1), 499);
    chk("R7 sw dir next edge stat", dir_stat[1], 1);
    aux_run[0] = 0;
    dir_sw[1] = 0;
    step(1);
    chk("R7 stat updates while stopped", dir_stat[1], 0);
    aux_run[0] = 1;

    // R8: wrap both ways on every counter
    for (int t = 0; t < NT; t++) begin
      dir_sw[t] = 0;
      load(t, 16'hFFFF);
      run_ticks(t, 1);
      chk("R8 wrap up", cnt_of(t), 16'h0000);
      dir_sw[t] = 1;
      run_ticks(t, 1);
      chk("R8 wrap down", cnt_of(t), 16'hFFFF);
      dir_sw[t] = 0;
      load(t, 16'hFFF0);
      run_ticks(t, 32);
      chk("R8 count across wrap", cnt_of(t), 16'h0010);
    end

    // R9: load beats counting in the same clock
    load(2, 16'd10);
    tick[2] = 1;
    load_en[2] = 1; load_val[2*W +: W] = 16'h1234;
    step(1);
    load_en[2] = 0;
    chk("R9 load priority", cnt_of(2), 16'h1234);
    step(1);
    tick[2] = 0;
    chk("R9 count resumes after load", cnt_of(2), 16'h1235);

    // R10: tick low holds
    step(5);
    chk("R10 hold without tick", cnt_of(2), 16'h1235);

    // R3 R2: gate sweep on the core counter
    for (int g = 0; g < 8; g++) begin
      load(0, 16'd0);
      gate_en = g[2]; gate_act_hi = g[1]; gate_pin = g[0];
      step(3);
      run_ticks(0, 4);
      chk("R3 gate sweep", cnt_of(0), (!g[2] || (g[0] == g[1])) ? 4 : 0);
    end
    gate_en = 0;
    load(0, 16'd0);
    core_run = 0;
    run_ticks(0, 4);
    chk("R2 core stopped", cnt_of(0), 0);
    gate_en = 1; gate_act_hi = 1; gate_pin = 1;
    step(3);
    run_ticks(0, 4);
    chk("R2 stopped despite active gate", cnt_of(0), 0);
    gate_en = 0;
    tick[0] = 1;
    core_run = 1; step(3);
    core_run = 0; step(3);
    tick[0] = 0;
    chk("R2 start then stop", cnt_of(0), 3);
    core_run = 1;

    // R3: gate pin change lands on the third edge
    gate_en = 1; gate_act_hi = 1; gate_pin = 0;
    load(0, 16'd0);
    step(3);
    gate_pin = 1; tick[0] = 1;
    step(2);
    chk("R3 gate not yet open", cnt_of(0), 0);
    step(1);
    tick[0] = 0;
    chk("R3 gate open on third edge", cnt_of(0), 1);
    gate_en = 0;

    // R4: remote run control sweep on the auxiliaries
    for (int a = 0; a < NA; a++) begin
      for (int c = 0; c < 8; c++) begin
        load(a + 1, 16'd0);
        aux_remote[a] = c[2]; core_run = c[1]; aux_run[a] = c[0];
        run_ticks(a + 1, 3);
        chk("R4 remote run sweep", cnt_of(a + 1), (c[2] ? c[1] : c[0]) ? 3 : 0);
      end
      aux_remote[a] = 0; core_run = 1; aux_run[a] = 1;
    end

    finish_run();
  end

endmodule